// File: doc/BRIEF.md
# Hypercube Broadcast Scheduler

This block models a binary hypercube of 2^N nodes (N is a parameter, 1 to 5) and spreads one message word from a chosen source node to every other node. A node only ever hands the message to a node whose address differs from its own in exactly one bit. A node sends on at most one link in any one step, and each hop takes one step.

A one-cycle start pulse loads the source id and the message word. During step t, every node that already holds the message sends it across dimension t. The node reached is the sender's address with bit t flipped. The set of holders therefore doubles on each step, and every node holds the message after exactly N steps. A node first reached at step t can only send on dimensions t+1 and above. The block exposes a flag per node that shows the message has arrived, that node's copy of the word, and a completion flag.

Top module: `hypercube_bcast`

## Requirements
- R1: After reset, every per-node received flag is 0, every per-node copy is 0 and `done` is 0.
- R2: A start accepted while idle clears all flags and copies. In the next cycle, only the source's flag (bit `src_in` of `rcvd`) is set, the source's copy equals `msg_in`, and `done` is 0.
- R3: k cycles after the state of R2 (k = 1..N), the set flags are exactly the nodes j with (j XOR source) < 2^k. This means dimension 0 is crossed first, then dimension 1, and so on.
- R4: In every step, each node receives over at most one link and never receives a message it already holds. The message only travels between addresses that differ in one bit.
- R5: `done` rises exactly N cycles after the state of R2, with all 2^N flags set. It stays high until the next accepted start.
- R6: When `done` is high, every node's copy equals the message word of the accepted start. Node j's copy is bits [j*MSG_W +: MSG_W] of `node_msg`.
- R7: A start pulse while a broadcast is in progress is ignored. The running broadcast keeps its source, its message and its step timing.
- R8: A node only sends in a step t for which its address relative to the source has no set bit at position t or above. A node reached at step t therefore forwards only on higher dimensions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a broadcast |
| src_in | input | DIM_N | Source node id, sampled with start |
| msg_in | input | MSG_W | Message word, sampled with start |
| rcvd | output | 2^DIM_N | Per-node flag: node holds the message |
| node_msg | output | 2^DIM_N*MSG_W | Per-node copy of the message, node j at bits [j*MSG_W +: MSG_W] |
| done | output | 1 | Broadcast complete, held until next start |

## Verification
The assertions check several properties on every cycle:
- each node gets at most one incoming transfer, and never a redundant one;
- only nodes eligible under the dimension rule send;
- the number of holders is 2^step while busy;
- completion implies full coverage;
- a start during a run does not disturb the step count.

Only the bench scenarios can show three further things: the exact set of holders after each step for several sources, that every copy carries the right word at the end, and that a rejected start leaves the original source and word in place.

// File: rtl/hcb_pkg.sv
package hcb_pkg;
    localparam int MAX_DIM = 5;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/hcb_step_seq.sv
module hcb_step_seq
    import hcb_pkg::*;
#(
    parameter int DIM_N  = 3,
    parameter int STEP_W = $clog2(DIM_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              launch,
    output logic              busy,
    output logic              done,
    output logic [STEP_W-1:0] step
);
    typedef struct packed {
        phase_e            phase;
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        launch = start && (seq_q.phase != PH_RUN);
        if (launch) begin
            seq_d.phase = PH_RUN;
            seq_d.step  = '0;
        end else if (seq_q.phase == PH_RUN) begin
            seq_d.step = seq_q.step + 1'b1;
            if (seq_d.step == STEP_W'(DIM_N)) begin
                seq_d.phase = PH_DONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.phase <= PH_IDLE;
            seq_q.step  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.phase == PH_RUN);
    assign done = (seq_q.phase == PH_DONE);
    assign step = seq_q.step;

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (step == $past(step) + 1'b1));

    assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step < STEP_W'(DIM_N)));
endmodule

// File: rtl/hcb_node_ctrl.sv
module hcb_node_ctrl #(
    parameter int DIM_N   = 3,
    parameter int STEP_W  = $clog2(DIM_N + 1),
    parameter int NODE_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              holds,
    input  logic [STEP_W-1:0] step,
    input  logic [DIM_N-1:0]  src,
    output logic              tx_en,
    output logic [STEP_W-1:0] tx_dim
);
    logic [DIM_N-1:0] rel_addr;

    assign rel_addr = DIM_N'(NODE_ID) ^ src;
    assign tx_en    = busy && holds;
    assign tx_dim   = step;

    assert_eligible_sender_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> ((rel_addr >> step) == '0));
endmodule

// File: rtl/hcb_fabric.sv
module hcb_fabric #(
    parameter int DIM_N  = 3,
    parameter int MSG_W  = 16,
    parameter int STEP_W = $clog2(DIM_N + 1),
    parameter int NODES  = 1 << DIM_N
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NODES-1:0]             tx_en,
    input  logic [NODES-1:0][STEP_W-1:0] tx_dim,
    input  logic [NODES-1:0][MSG_W-1:0]  tx_data,
    input  logic [NODES-1:0]             holds,
    output logic [NODES-1:0]             rx_valid,
    output logic [NODES-1:0][MSG_W-1:0]  rx_data
);
    for (genvar j = 0; j < NODES; j++) begin : g_rx
        logic [DIM_N-1:0] hit;

        for (genvar d = 0; d < DIM_N; d++) begin : g_link
            assign hit[d] = tx_en[j ^ (1 << d)] &&
                            (tx_dim[j ^ (1 << d)] == STEP_W'(d));
        end

        always_comb begin
            rx_data[j] = '0;
            for (int d = 0; d < DIM_N; d++) begin
                if (hit[d]) rx_data[j] = rx_data[j] | tx_data[j ^ (1 << d)];
            end
        end

        assign rx_valid[j] = |hit;

        assert_one_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hit));

        assert_fresh_receiver_R4: assert property (@(posedge clk) disable iff (!rst_n)
            rx_valid[j] |-> !holds[j]);
    end
endmodule

// File: rtl/hypercube_bcast.sv
module hypercube_bcast
    import hcb_pkg::*;
#(
    parameter int DIM_N  = 3,
    parameter int MSG_W  = 16,
    localparam int NODES  = 1 << DIM_N,
    localparam int STEP_W = $clog2(DIM_N + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [DIM_N-1:0]       src_in,
    input  logic [MSG_W-1:0]       msg_in,
    output logic [NODES-1:0]       rcvd,
    output logic [NODES*MSG_W-1:0] node_msg,
    output logic                   done
);
    typedef struct packed {
        logic [DIM_N-1:0]            src;
        logic [NODES-1:0]            have;
        logic [NODES-1:0][MSG_W-1:0] msgs;
    } net_t;

    net_t net_d, net_q;

    logic                         launch;
    logic                         busy;
    logic [STEP_W-1:0]            step;
    logic [NODES-1:0]             tx_en;
    logic [NODES-1:0][STEP_W-1:0] tx_dim;
    logic [NODES-1:0]             rx_valid;
    logic [NODES-1:0][MSG_W-1:0]  rx_data;

    hcb_step_seq #(.DIM_N(DIM_N), .STEP_W(STEP_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .launch (launch),
        .busy   (busy),
        .done   (done),
        .step   (step)
    );

    for (genvar j = 0; j < NODES; j++) begin : g_node
        hcb_node_ctrl #(.DIM_N(DIM_N), .STEP_W(STEP_W), .NODE_ID(j)) u_ctrl (
            .clk    (clk),
            .rst_n  (rst_n),
            .busy   (busy),
            .holds  (net_q.have[j]),
            .step   (step),
            .src    (net_q.src),
            .tx_en  (tx_en[j]),
            .tx_dim (tx_dim[j])
        );
    end

    hcb_fabric #(.DIM_N(DIM_N), .MSG_W(MSG_W), .STEP_W(STEP_W), .NODES(NODES)) u_fabric (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .tx_dim   (tx_dim),
        .tx_data  (net_q.msgs),
        .holds    (net_q.have),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );

    always_comb begin
        net_d = net_q;
        if (launch) begin
            net_d.src  = src_in;
            net_d.have = '0;
            net_d.msgs = '0;
            net_d.have[src_in] = 1'b1;
            net_d.msgs[src_in] = msg_in;
        end else if (busy) begin
            for (int j = 0; j < NODES; j++) begin
                if (rx_valid[j]) begin
                    net_d.have[j] = 1'b1;
                    net_d.msgs[j] = rx_data[j];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            net_q <= '0;
        end else begin
            net_q <= net_d;
        end
    end

    assign rcvd     = net_q.have;
    assign node_msg = net_q.msgs;

    assert_holder_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(net_q.have) == (32'(1) << step)));

    assert_full_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&net_q.have));

    assert_source_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !launch) |=> (net_q.src == $past(net_q.src)));
endmodule

// File: tb/tb_hypercube_bcast.sv
module tb_hypercube_bcast;
    localparam int CLK_PERIOD = 10;
    localparam int DIM_N = 3;
    localparam int MSG_W = 16;
    localparam int NODES = 1 << DIM_N;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic [DIM_N-1:0]       src_in = '0;
    logic [MSG_W-1:0]       msg_in = '0;
    logic [NODES-1:0]       rcvd;
    logic [NODES*MSG_W-1:0] node_msg;
    logic                   done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    hypercube_bcast #(.DIM_N(DIM_N), .MSG_W(MSG_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_in(src_in),
        .msg_in(msg_in), .rcvd(rcvd), .node_msg(node_msg), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [NODES-1:0] holders(int src, int k);
        logic [NODES-1:0] m = '0;
        for (int j = 0; j < NODES; j++) if ((j ^ src) < (1 << k)) m[j] = 1'b1;
        return m;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch_cmd(int src, logic [MSG_W-1:0] msg);
        @(negedge clk);
        start = 1'b1; src_in = DIM_N'(src); msg_in = msg;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        check(rcvd == '0, "R1 rcvd", rcvd, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(node_msg == '0, "R1 copies", node_msg, 0);
    endtask

    task automatic t_broadcast(int src, logic [MSG_W-1:0] msg);
        launch_cmd(src, msg);
        check(rcvd == (NODES'(1) << src), "R2 only source", rcvd, NODES'(1) << src);
        check(done == 1'b0, "R2 done low", done, 0);
        check(node_msg[src*MSG_W +: MSG_W] == msg, "R2 source copy",
              node_msg[src*MSG_W +: MSG_W], msg);
        for (int j = 0; j < NODES; j++)
            if (j != src)
                check(node_msg[j*MSG_W +: MSG_W] == '0, "R2 others cleared",
                      node_msg[j*MSG_W +: MSG_W], 0);
        for (int k = 1; k <= DIM_N; k++) begin
            @(negedge clk);
            check(rcvd == holders(src, k), "R3 holder set", rcvd, holders(src, k));
            check(done == (k == DIM_N), "R5 done timing", done, (k == DIM_N));
        end
        for (int j = 0; j < NODES; j++)
            check(node_msg[j*MSG_W +: MSG_W] == msg, "R6 copy",
                  node_msg[j*MSG_W +: MSG_W], msg);
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R5 done held", done, 1);
        check(&rcvd, "R5 all flags", rcvd, {NODES{1'b1}});
    endtask

    task automatic t_ignore_busy();
        logic [MSG_W-1:0] a = 16'h1234;
        logic [MSG_W-1:0] b = 16'hBEEF;
        launch_cmd(2, a);
        start = 1'b1; src_in = DIM_N'(6); msg_in = b;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(rcvd == holders(2, 2), "R7 run undisturbed", rcvd, holders(2, 2));
        for (int k = 3; k <= DIM_N; k++) @(negedge clk);
        check(done == 1'b1, "R7 done on time", done, 1);
        for (int j = 0; j < NODES; j++)
            check(node_msg[j*MSG_W +: MSG_W] == a, "R7 original word",
                  node_msg[j*MSG_W +: MSG_W], a);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_broadcast(0, 16'hA5C3);
        t_broadcast(5, 16'h0F0F);
        t_broadcast(7, 16'hFFFF);
        t_ignore_busy();
        t_broadcast(3, 16'h8001);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule